// File: doc/BRIEF.md
# Decimal Nines-Complement Subtractor

This block takes two unsigned packed-BCD operands of equal digit count and subtracts the second one from the first. It never uses a borrow chain. Each subtrahend digit is mapped to nine minus itself, one digit at a time, and the result is added to the minuend on one chain of decimal digit adders. The carry that leaves the top digit gives the sign. A second pass on the same kind of adder then turns the raw sum into a sign plus a BCD magnitude. On a positive result that pass feeds the carry back into the bottom digit. On a negative result it re-complements the sum.

A mode input selects the tens-complement variant. In that variant the first addition runs with a carry-in of one, and the correction pass changes to match. Both modes give the same magnitude and sign for the same operands. A shorter operand is zero-padded to the full width by the caller. Digit 0, the least significant, sits in bits [3:0].

A start strobe captures the operands and the mode. The result and a one-cycle done pulse appear a fixed two cycles later. The outputs then hold until the next result replaces them.

Top module: `bcd_nines_sub`

## Requirements
- R1: In nines mode (`tens_mode`=0) the first sum is minuend plus the per-digit nines complement of the subtrahend, with carry-in 0. If a carry leaves the top digit, `negative`=0 and `magnitude` is that sum plus one, e.g. 0873-0421 gives 0452.
- R2: In nines mode, if no carry leaves the top digit, `negative`=1 and `magnitude` is the per-digit nines complement of the sum, e.g. 0042-0873 gives 0831 negative.
- R3: In tens mode (`tens_mode`=1) the first sum uses carry-in 1. On a top carry, `magnitude` is that sum and `negative`=0. With no top carry, `magnitude` is the nines complement of the sum plus one and `negative`=1. In both modes `magnitude` equals |minuend - subtrahend| and fits in the digit count.
- R4: Equal operands give `magnitude`=0 with `negative`=0 in both modes. `negative` is never 1 while `magnitude` is zero.
- R5: `invalid` is 1 for a result whose captured minuend or subtrahend held any nibble above 9, and 0 otherwise. `magnitude` is then undefined.
- R6: `done` is high for exactly the one cycle that comes two cycles after the cycle in which `start` was sampled high.
- R7: `magnitude`, `negative` and `invalid` change only together with a `done` pulse, and hold between pulses.
- R8: While `rst_n` is low, `done`, `magnitude`, `negative` and `invalid` are all 0.
- R9: Each digit adder adds 6 to a binary digit sum above 9 and carries into the next digit. Every `magnitude` digit of a valid result lies in 0..9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures operands and mode |
| tens_mode | input | 1 | 1 selects tens-complement carry-in |
| minuend | input | 4*DIGITS | Packed BCD minuend, digit 0 in [3:0] |
| subtrahend | input | 4*DIGITS | Packed BCD subtrahend, zero-padded |
| magnitude | output | 4*DIGITS | Packed BCD magnitude of the difference |
| negative | output | 1 | Result sign, 1 when subtrahend exceeds minuend |
| invalid | output | 1 | A captured operand nibble exceeded 9 |
| done | output | 1 | One-cycle result strobe |

## Verification
Every result is due in the second cycle after `start` is sampled. The first register stage holds the raw sum and its carry, and the second holds the corrected outputs. The bench drives inputs on the falling edge and samples on a falling edge only. It expects `done` low one cycle after start, `done` high with the expected sign, magnitude and invalid flag one cycle later, and `done` low with unchanged outputs in the cycle after that. Reset values are read while reset is still asserted, before any start.

// File: rtl/bcd_sub_pkg.sv
package bcd_sub_pkg;
   typedef logic [3:0] bcd_digit_t;

   localparam bcd_digit_t BCD_TOP = 4'd9;

   // Digit-wise nines complement: no borrow between digits.
   function automatic bcd_digit_t nine_of(input bcd_digit_t d);
      return BCD_TOP - d;
   endfunction

   function automatic logic digit_bad(input bcd_digit_t d);
      return d > BCD_TOP;
   endfunction
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
   import bcd_sub_pkg::*;
(
   input  bcd_digit_t a,
   input  bcd_digit_t b,
   input  logic       ci,
   output bcd_digit_t s,
   output logic       co
);
   logic [4:0] raw;

   assign raw = {1'b0, a} + {1'b0, b} + {4'b0000, ci};
   // decimal correction: above nine wraps by adding six, carry out
   assign co  = raw > 5'd9;
   assign s   = co ? (raw[3:0] + 4'd6) : raw[3:0];
endmodule

// File: rtl/bcd_ripple_add.sv
module bcd_ripple_add #(
   parameter int DIGITS = 4,
   localparam int W     = 4 * DIGITS
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         ci,
   output logic [W-1:0] sum,
   output logic         co
);
   logic [DIGITS:0] carry;

   assign carry[0] = ci;

   for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      bcd_digit_add i_digit (
         .a  (a[4*i +: 4]),
         .b  (b[4*i +: 4]),
         .ci (carry[i]),
         .s  (sum[4*i +: 4]),
         .co (carry[i+1])
      );
   end

   assign co = carry[DIGITS];
endmodule

// File: rtl/bcd_nines_vec.sv
module bcd_nines_vec
   import bcd_sub_pkg::*;
#(
   parameter int DIGITS = 4,
   localparam int W     = 4 * DIGITS
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      assign dout[4*i +: 4] = nine_of(din[4*i +: 4]);
   end
endmodule

// File: rtl/bcd_nines_sub.sv
module bcd_nines_sub
   import bcd_sub_pkg::*;
#(
   parameter int DIGITS = 4,
   localparam int W     = 4 * DIGITS
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         tens_mode,
   input  logic [W-1:0] minuend,
   input  logic [W-1:0] subtrahend,
   output logic [W-1:0] magnitude,
   output logic         negative,
   output logic         invalid,
   output logic         done
);
   localparam logic [W-1:0] ZERO_V = '0;

   if (DIGITS < 1) begin : g_bad_digits
      $error("bcd_nines_sub: DIGITS must be at least 1");
   end

   // ---------------- stage 1: complement and first addition -------------
   logic [W-1:0]      sub_nc;
   logic [W-1:0]      sum1;
   logic              cout1;
   logic [DIGITS-1:0] bad_dig;

   bcd_nines_vec #(.DIGITS(DIGITS)) i_sub_nc (
      .din  (subtrahend),
      .dout (sub_nc)
   );

   bcd_ripple_add #(.DIGITS(DIGITS)) i_add1 (
      .a   (minuend),
      .b   (sub_nc),
      .ci  (tens_mode),
      .sum (sum1),
      .co  (cout1)
   );

   for (genvar i = 0; i < DIGITS; i++) begin : g_chk
      assign bad_dig[i] = digit_bad(minuend[4*i +: 4])
                        | digit_bad(subtrahend[4*i +: 4]);
   end

   logic         s1_valid;
   logic [W-1:0] s1_sum;
   logic         s1_cout;
   logic         s1_tens;
   logic         s1_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_sum   <= '0;
         s1_cout  <= 1'b0;
         s1_tens  <= 1'b0;
         s1_bad   <= 1'b0;
      end else begin
         s1_valid <= start;
         if (start) begin
            s1_sum  <= sum1;
            s1_cout <= cout1;
            s1_tens <= tens_mode;
            s1_bad  <= |bad_dig;
         end
      end
   end

   // ---------------- stage 2: end-around carry or re-complement ---------
   logic [W-1:0] sum_nc;
   logic [W-1:0] fix_in;
   logic         fix_ci;
   logic [W-1:0] mag_next;
   logic         cout2;
   logic         neg_next;

   bcd_nines_vec #(.DIGITS(DIGITS)) i_sum_nc (
      .din  (s1_sum),
      .dout (sum_nc)
   );

   // Positive: keep the sum. Negative: use its nines complement.
   // The increment is the end-around carry (nines mode, positive)
   // or the plus-one of the tens complement (tens mode, negative).
   assign fix_in = s1_cout ? s1_sum : sum_nc;
   assign fix_ci = s1_tens ? ~s1_cout : s1_cout;

   bcd_ripple_add #(.DIGITS(DIGITS)) i_add2 (
      .a   (fix_in),
      .b   (ZERO_V),
      .ci  (fix_ci),
      .sum (mag_next),
      .co  (cout2)
   );

   // No top carry means negative, except that a zero magnitude is never signed.
   assign neg_next = ~s1_cout & (mag_next != ZERO_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         magnitude <= '0;
         negative  <= 1'b0;
         invalid   <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= s1_valid;
         if (s1_valid) begin
            magnitude <= mag_next;
            negative  <= neg_next;
            invalid   <= s1_bad;
         end
      end
   end

   // ---------------- assertions ----------------------------------------
   AST_NO_FINAL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && !s1_bad) |-> !cout2);                                 // R3

   AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      negative |-> (magnitude != ZERO_V));                               // R4

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done == $past(start, 2));                                          // R6

   AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(magnitude) && $stable(negative) && $stable(invalid))); // R7

   for (genvar i = 0; i < DIGITS; i++) begin : g_ast
      AST_MAG_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
         (done && !invalid) |-> (magnitude[4*i +: 4] <= BCD_TOP));        // R9
   end
endmodule

// File: tb/test_bcd_nines_sub.sv
module test_bcd_nines_sub;
   localparam int DIGITS = 4;
   localparam int W      = 4 * DIGITS;
   localparam int NVEC   = 11;

   typedef struct packed {
      logic         tens;
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic [W-1:0] mag;
      logic         neg;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 16'h0873, 16'h0421, 16'h0452, 1'b0},   // R1
      '{1'b0, 16'h0042, 16'h0873, 16'h0831, 1'b1},   // R2
      '{1'b0, 16'h1234, 16'h1234, 16'h0000, 1'b0},   // R4
      '{1'b0, 16'h0000, 16'h9999, 16'h9999, 1'b1},   // R2
      '{1'b0, 16'h9999, 16'h0000, 16'h9999, 1'b0},   // R1
      '{1'b1, 16'h0873, 16'h0421, 16'h0452, 1'b0},   // R3
      '{1'b1, 16'h0042, 16'h0873, 16'h0831, 1'b1},   // R3
      '{1'b1, 16'h5555, 16'h5555, 16'h0000, 1'b0},   // R4
      '{1'b0, 16'h1000, 16'h0001, 16'h0999, 1'b0},   // R9 carry through nines
      '{1'b1, 16'h0001, 16'h1000, 16'h0999, 1'b1},   // R3
      '{1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0}    // R4
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         tens_mode = 1'b0;
   logic [W-1:0] minuend = '0;
   logic [W-1:0] subtrahend = '0;
   logic [W-1:0] magnitude;
   logic         negative;
   logic         invalid;
   logic         done;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;   // 250 MHz

   bcd_nines_sub #(.DIGITS(DIGITS)) i_bcd_nines_sub (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .tens_mode  (tens_mode),
      .minuend    (minuend),
      .subtrahend (subtrahend),
      .magnitude  (magnitude),
      .negative   (negative),
      .invalid    (invalid),
      .done       (done)
   );

   task automatic check(input string req, input string what,
                        input logic [W:0] act, input logic [W:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Start on a falling edge; returns at the falling edge of the done cycle.
   task automatic run(input logic tm, input logic [W-1:0] a, input logic [W-1:0] b);
      tens_mode  = tm;
      minuend    = a;
      subtrahend = b;
      start      = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check("R6", "done one cycle after start", {{W{1'b0}}, done}, '0);
      @(posedge clk);
      @(negedge clk);
      check("R6", "done two cycles after start", {{W{1'b0}}, done}, {{W{1'b0}}, 1'b1});
   endtask

   task automatic check_hold(input logic [W-1:0] m, input logic n);
      @(posedge clk);
      @(negedge clk);
      check("R6", "done single cycle", {{W{1'b0}}, done}, '0);
      check("R7", "magnitude held", {1'b0, magnitude}, {1'b0, m});
      check("R7", "negative held", {{W{1'b0}}, negative}, {{W{1'b0}}, n});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R8", "reset done", {{W{1'b0}}, done}, '0);
      check("R8", "reset magnitude", {1'b0, magnitude}, '0);
      check("R8", "reset negative", {{W{1'b0}}, negative}, '0);
      check("R8", "reset invalid", {{W{1'b0}}, invalid}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         run(VECS[i].tens, VECS[i].a, VECS[i].b);
         check("R1 R2 R3 R9", "magnitude", {1'b0, magnitude}, {1'b0, VECS[i].mag});
         check("R2 R4", "negative", {{W{1'b0}}, negative}, {{W{1'b0}}, VECS[i].neg});
         check("R5", "invalid clear", {{W{1'b0}}, invalid}, '0);
         check_hold(VECS[i].mag, VECS[i].neg);
      end

      // R5: nibble 0xA in the minuend, then 0xF in the subtrahend
      run(1'b0, 16'h0A12, 16'h0000);
      check("R5", "invalid minuend", {{W{1'b0}}, invalid}, {{W{1'b0}}, 1'b1});
      run(1'b1, 16'h0312, 16'h00F0);
      check("R5", "invalid subtrahend", {{W{1'b0}}, invalid}, {{W{1'b0}}, 1'b1});
      run(1'b0, 16'h0500, 16'h0499);
      check("R5", "invalid cleared", {{W{1'b0}}, invalid}, '0);
      check("R1", "end-around 0500-0499", {1'b0, magnitude}, {1'b0, 16'h0001});

      // R7: operand changes without start leave outputs untouched
      minuend    = 16'h9000;
      subtrahend = 16'h0001;
      tens_mode  = 1'b1;
      repeat (3) @(negedge clk);
      check("R7", "no start, magnitude held", {1'b0, magnitude}, {1'b0, 16'h0001});
      check("R6", "no start, no done", {{W{1'b0}}, done}, '0);

      // R8: reset after activity clears the outputs
      rst_n = 1'b0;
      @(negedge clk);
      check("R8", "reset clears magnitude", {1'b0, magnitude}, '0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule